// File: doc/BRIEF.md
# Floating-Point Coprocessor Register Front End

This block sits between a processor bus and a floating-point arithmetic unit. Software sees a window of 33 words. The first 32 words are a 32 x 32-bit operand register file. The last word is a configuration and status word. Software loads operands into the register file. It then writes one configuration word, which names the two source registers, the destination register, the precision and a 4-bit mode value for the arithmetic unit. That same write starts the operation.

A sequencer reads the source operands out of the register file. In double precision it reads two words per operand. In single precision it reads one word and widens it to the 64-bit double layout. It presents both operands to the arithmetic unit with a one-cycle start pulse and waits for the unit's done signal. It then writes the result back to the register file, as two words or as one, and stores the five result flags in the status word.

While an operation is in progress the block reports busy, and it ignores every bus write. The arithmetic unit itself lives outside this block.

Top module: `fpu_front_end`

## Requirements
- R1: Reset behaviour. After reset the block is idle. The configuration word reads as 0, with the busy bit and all flags clear, and `fu_start` is low.
- R2: Register file access and read latency. A bus write to byte address BASE_ADDR + 4*i, for i from 0 to 31, stores the write data in register i. A bus read of that address returns register i on `bus_rdata` in the cycle after the request. A read of any other word in the window returns 0, for example word offset 40.
- R3: Configuration write and launch. A write to BASE_ADDR + 0x80 while idle does three things. It stores write-data bits [19:0]: A index in [4:0], B index in [9:5], destination index in [14:10], double select in [15] (1 = double) and mode in [19:16]. It starts an operation. It leaves the flags unchanged, because write-data bits [31:20] are discarded. The configuration word then reads as {flags[4:0], 6'b0, busy, cfg[19:0]}, with busy at bit 20 set for as long as the sequencer is not idle.
- R4: Double-precision operand pairs. In double mode an index selects the register pair {index with bit 0 cleared, index with bit 0 set}. The operand is {reg[even], reg[odd]}, so the even register holds bits [63:32].
- R5: Single-precision widening. In single mode the named register is widened to double layout. The sign is kept. An exponent of 0 gives a signed zero. An exponent of 255 gives exponent 0x7FF with the fraction shifted left by 29. Any other exponent e gives exponent e+896 with the fraction shifted left by 29.
- R6: Start pulse and held operands. `fu_start` is high for exactly one cycle once both operands are on `fu_op_a` and `fu_op_b`. The operands stay constant until the operation ends. `fu_dp` and `fu_mode` reflect cfg bit 15 and cfg bits [19:16].
- R7: Double-precision write-back. In double mode, `fu_result[63:32]` goes to the even register of the destination pair and `fu_result[31:0]` goes to the odd register.
- R8: Single-precision write-back. In single mode only `fu_result[31:0]` is written, into the destination register. No other register changes.
- R9: Flags and busy clear. `fu_flags` is captured in the cycle `fu_done` is high and appears in bits [31:27] of the configuration word when the operation completes. At the same point busy clears. The flags change at no other time except reset.
- R10: Writes ignored while busy. While busy, bus writes to the register file and to the configuration word have no effect.
- R11: Base address match. Accesses whose address bits [31:8] differ from BASE_ADDR[31:8] are ignored, and so are accesses that are not word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus transfer valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| fu_start | output | 1 | One-cycle start pulse to the arithmetic unit |
| fu_dp | output | 1 | Precision select to the arithmetic unit |
| fu_mode | output | 4 | Trap/rounding/precision control to the arithmetic unit |
| fu_op_a | output | 64 | Operand A in double layout |
| fu_op_b | output | 64 | Operand B in double layout |
| fu_done | input | 1 | Arithmetic unit result valid |
| fu_result | input | 64 | Arithmetic unit result |
| fu_flags | input | 5 | Arithmetic unit flags |

## Verification
The main function is exercised with a table of six operations. The table mixes double and single precision, odd and even operand and destination indices, and a destination that overlaps a source. These cases separate correct pair decoding and half ordering from swapped or unmasked indices. Single operands are drawn from zero-exponent, all-ones-exponent and normal words, so each widening branch is tested on its own. After every operation the whole register file is read back, which exposes stray writes, writes landing in the wrong half, and writes that should have been ignored while busy. The configuration word is also read back, which shows whether the flags and busy bit update at the right moment.

// File: rtl/fpu_fe_pkg.sv
package fpu_fe_pkg;
  localparam int WORD_W  = 32;
  localparam int DWORD_W = 64;
  localparam int IDX_W   = 5;
  localparam int RF_DEPTH = 1 << IDX_W;
  localparam int FLAG_W  = 5;
  localparam int MODE_W  = 4;
  localparam int CFG_W   = 20;

  // configuration word field positions (decoded by the sequencer)
  localparam int F_A    = 0;
  localparam int F_B    = 5;
  localparam int F_D    = 10;
  localparam int F_DP   = 15;
  localparam int F_MODE = 16;
  localparam int F_BUSY = 20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_WR_HI, ST_WR_LO, ST_DONE
  } seq_state_t;
endpackage

// File: rtl/fpu_fe_regfile.sv
module fpu_fe_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/fpu_fe_widen.sv
module fpu_fe_widen (
  input  logic [31:0] s_in,
  output logic [63:0] d_out
);
  logic        sgn;
  logic [7:0]  exp8;
  logic [22:0] frac;

  always_comb begin
    sgn  = s_in[31];
    exp8 = s_in[30:23];
    frac = s_in[22:0];
    if (exp8 == 8'd0)
      d_out = {sgn, 63'd0};
    else if (exp8 == 8'hFF)
      d_out = {sgn, 11'h7FF, frac, 29'd0};
    else
      d_out = {sgn, {3'd0, exp8} + 11'd896, frac, 29'd0};
  end
endmodule

// File: rtl/fpu_fe_seq.sv
module fpu_fe_seq
  import fpu_fe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               dp,
  input  logic [IDX_W-1:0]   a_idx,
  input  logic [IDX_W-1:0]   b_idx,
  input  logic [IDX_W-1:0]   d_idx,
  input  logic [WORD_W-1:0]  rd_data,
  input  logic               fu_done,
  input  logic [DWORD_W-1:0] fu_result,
  input  logic [FLAG_W-1:0]  fu_flags,
  output seq_state_t         state,
  output logic [IDX_W-1:0]   rd_addr,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic               start,
  output logic [WORD_W-1:0]  a_hi,
  output logic [WORD_W-1:0]  a_lo,
  output logic [WORD_W-1:0]  b_hi,
  output logic [WORD_W-1:0]  b_lo,
  output logic               flag_we,
  output logic [FLAG_W-1:0]  flag_val
);
  logic [2:0]         cnt_q;
  logic [2:0]         last_cnt;
  logic [DWORD_W-1:0] res_q;
  logic [FLAG_W-1:0]  flg_q;

  assign last_cnt = dp ? 3'd4 : 3'd2;

  // operand fetch address: double reads pairs high word first
  always_comb begin
    if (dp) begin
      case (cnt_q[1:0])
        2'd0:    rd_addr = {a_idx[IDX_W-1:1], 1'b0};
        2'd1:    rd_addr = {a_idx[IDX_W-1:1], 1'b1};
        2'd2:    rd_addr = {b_idx[IDX_W-1:1], 1'b0};
        default: rd_addr = {b_idx[IDX_W-1:1], 1'b1};
      endcase
    end else begin
      rd_addr = cnt_q[0] ? b_idx : a_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt_q <= '0;
      start <= 1'b0;
      a_hi  <= '0;
      a_lo  <= '0;
      b_hi  <= '0;
      b_lo  <= '0;
      res_q <= '0;
      flg_q <= '0;
    end else begin
      start <= 1'b0;
      case (state)
        ST_IDLE: if (launch) begin
          state <= ST_FETCH;
          cnt_q <= '0;
          a_hi  <= '0;
          b_hi  <= '0;
        end
        ST_FETCH: begin
          cnt_q <= cnt_q + 3'd1;
          if (dp) begin
            case (cnt_q)
              3'd1: a_hi <= rd_data;
              3'd2: a_lo <= rd_data;
              3'd3: b_hi <= rd_data;
              3'd4: b_lo <= rd_data;
              default: ;
            endcase
          end else begin
            case (cnt_q)
              3'd1: a_lo <= rd_data;
              3'd2: b_lo <= rd_data;
              default: ;
            endcase
          end
          if (cnt_q == last_cnt) begin
            state <= ST_EXEC;
            start <= 1'b1;
          end
        end
        ST_EXEC: if (fu_done) begin
          res_q <= fu_result;
          flg_q <= fu_flags;
          state <= dp ? ST_WR_HI : ST_WR_LO;
        end
        ST_WR_HI: state <= ST_WR_LO;
        ST_WR_LO: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = (state == ST_WR_HI) || (state == ST_WR_LO);
    if (state == ST_WR_HI) begin
      wr_addr = {d_idx[IDX_W-1:1], 1'b0};
      wr_data = res_q[DWORD_W-1:WORD_W];
    end else begin
      wr_addr = dp ? {d_idx[IDX_W-1:1], 1'b1} : d_idx;
      wr_data = res_q[WORD_W-1:0];
    end
    flag_we  = (state == ST_DONE);
    flag_val = flg_q;
  end
endmodule

// File: rtl/fpu_front_end.sv
module fpu_front_end
  import fpu_fe_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hA016_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_write,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        fu_start,
  output logic        fu_dp,
  output logic [3:0]  fu_mode,
  output logic [63:0] fu_op_a,
  output logic [63:0] fu_op_b,
  input  logic        fu_done,
  input  logic [63:0] fu_result,
  input  logic [4:0]  fu_flags
);
  localparam int OFF_W   = IDX_W + 1;
  localparam int WIN_LSB = OFF_W + 2;

  seq_state_t          state_q;
  logic                base_hit, rf_hit, ctl_hit, busy, launch, cpu_wr_rf;
  logic [OFF_W-1:0]    word_off;
  logic [CFG_W-1:0]    cfg_q;
  logic [FLAG_W-1:0]   flag_q;
  logic [WORD_W-1:0]   ctrl_word, ctrl_snap_q, cpu_rd, eng_rd;
  logic [1:0]          rd_src_q;
  logic [IDX_W-1:0]    eng_raddr, eng_waddr, rf_waddr;
  logic                eng_we, rf_we, flag_we;
  logic [WORD_W-1:0]   eng_wdata, rf_wdata;
  logic [FLAG_W-1:0]   flag_val;
  logic [WORD_W-1:0]   hi_w [2];
  logic [WORD_W-1:0]   lo_w [2];
  logic [DWORD_W-1:0]  wide_w [2];
  logic                unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[WORD_W-1:CFG_W];

  // address decode: word-aligned accesses inside the base window
  assign base_hit  = bus_sel && (bus_addr[31:WIN_LSB] == BASE_ADDR[31:WIN_LSB])
                     && (bus_addr[1:0] == 2'b00);
  assign word_off  = bus_addr[WIN_LSB-1:2];
  assign rf_hit    = base_hit && !word_off[OFF_W-1];
  assign ctl_hit   = base_hit && (word_off == OFF_W'(RF_DEPTH));
  assign busy      = (state_q != ST_IDLE);
  assign launch    = ctl_hit && bus_write && !busy;
  assign cpu_wr_rf = rf_hit && bus_write && !busy;

  assign ctrl_word = {flag_q, 6'd0, busy, cfg_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      flag_q <= '0;
    end else begin
      if (launch)  cfg_q  <= bus_wdata[CFG_W-1:0];
      if (flag_we) flag_q <= flag_val;
    end
  end

  // write port shared: the engine only writes while the bus is locked out
  assign rf_we    = cpu_wr_rf || eng_we;
  assign rf_waddr = eng_we ? eng_waddr : word_off[IDX_W-1:0];
  assign rf_wdata = eng_we ? eng_wdata : bus_wdata;

  fpu_fe_regfile #(.W(WORD_W), .DEPTH(RF_DEPTH)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .ra_addr (word_off[IDX_W-1:0]),
    .ra_data (cpu_rd),
    .rb_addr (eng_raddr),
    .rb_data (eng_rd)
  );

  fpu_fe_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .dp        (cfg_q[F_DP]),
    .a_idx     (cfg_q[F_A +: IDX_W]),
    .b_idx     (cfg_q[F_B +: IDX_W]),
    .d_idx     (cfg_q[F_D +: IDX_W]),
    .rd_data   (eng_rd),
    .fu_done   (fu_done),
    .fu_result (fu_result),
    .fu_flags  (fu_flags),
    .state     (state_q),
    .rd_addr   (eng_raddr),
    .wr_en     (eng_we),
    .wr_addr   (eng_waddr),
    .wr_data   (eng_wdata),
    .start     (fu_start),
    .a_hi      (hi_w[0]),
    .a_lo      (lo_w[0]),
    .b_hi      (hi_w[1]),
    .b_lo      (lo_w[1]),
    .flag_we   (flag_we),
    .flag_val  (flag_val)
  );

  for (genvar g = 0; g < 2; g++) begin : g_widen
    fpu_fe_widen u_widen (.s_in(lo_w[g]), .d_out(wide_w[g]));
  end

  assign fu_dp   = cfg_q[F_DP];
  assign fu_mode = cfg_q[F_MODE +: MODE_W];
  assign fu_op_a = fu_dp ? {hi_w[0], lo_w[0]} : wide_w[0];
  assign fu_op_b = fu_dp ? {hi_w[1], lo_w[1]} : wide_w[1];

  // read data: source chosen at request, data presented next cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_src_q    <= 2'd0;
      ctrl_snap_q <= '0;
    end else begin
      rd_src_q    <= (bus_sel && !bus_write) ? (rf_hit ? 2'd1 : (ctl_hit ? 2'd2 : 2'd0)) : 2'd0;
      ctrl_snap_q <= ctrl_word;
    end
  end

  always_comb begin
    case (rd_src_q)
      2'd1:    bus_rdata = cpu_rd;
      2'd2:    bus_rdata = ctrl_snap_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fpu_fe_chk.sv
module fpu_fe_chk
  import fpu_fe_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_write,
  input logic             busy,
  input logic             launch,
  input seq_state_t       state_q,
  input logic [CFG_W-1:0] cfg_q,
  input logic [FLAG_W-1:0] flag_q,
  input logic             fu_start,
  input logic [63:0]      fu_op_a,
  input logic [63:0]      fu_op_b
);
  p_launch_r3: assert property (@(posedge clk) disable iff (rst)
    launch |=> (state_q == ST_FETCH));

  p_start_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    fu_start |=> !fu_start);

  p_op_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_EXEC) |=> ($stable(fu_op_a) && $stable(fu_op_b)));

  p_flag_only_done_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_DONE) |=> $stable(flag_q));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_sel && bus_write) |=> $stable(cfg_q));
endmodule

bind fpu_front_end fpu_fe_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_write (bus_write),
  .busy      (busy),
  .launch    (launch),
  .state_q   (state_q),
  .cfg_q     (cfg_q),
  .flag_q    (flag_q),
  .fu_start  (fu_start),
  .fu_op_a   (fu_op_a),
  .fu_op_b   (fu_op_b)
);

// File: tb/test_fpu_front_end.sv
module test_fpu_front_end;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hA016_0000;
  localparam logic [31:0] CTRL = BASE + 32'h80;
  localparam int NV = 6;
  // {mode[3:0], dp, dst[4:0], b[4:0], a[4:0]}
  localparam logic [19:0] VEC [NV] = '{
    {4'h3, 1'b1, 5'd8,  5'd5, 5'd2},
    {4'h0, 1'b0, 5'd11, 5'd5, 5'd4},
    {4'h5, 1'b0, 5'd6,  5'd7, 5'd6},
    {4'h8, 1'b1, 5'd13, 5'd9, 5'd9},
    {4'hF, 1'b0, 5'd0,  5'd1, 5'd11},
    {4'h1, 1'b1, 5'd31, 5'd0, 5'd30}
  };

  logic        clk = 0, rst = 1;
  logic        bus_sel = 0, bus_write = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic        fu_start, fu_dp, fu_done = 0;
  logic [3:0]  fu_mode;
  logic [63:0] fu_op_a, fu_op_b, fu_result = 0;
  logic [4:0]  fu_flags = 0;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [31:0] exp_rf [32];
  logic [31:0] rd;
  logic [4:0]  cur_flags;

  fpu_front_end #(.BASE_ADDR(BASE)) i_fpu_front_end (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fu_start(fu_start), .fu_dp(fu_dp), .fu_mode(fu_mode),
    .fu_op_a(fu_op_a), .fu_op_b(fu_op_b), .fu_done(fu_done),
    .fu_result(fu_result), .fu_flags(fu_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] pat(input int i);
    logic [7:0] e;
    case (i % 4)
      0: e = 8'd0;
      1: e = 8'hFF;
      default: e = 8'(100 + i);
    endcase
    return {i[0], e, 23'(i * 32'h1357)};
  endfunction

  function automatic logic [63:0] widen(input logic [31:0] s);
    if (s[30:23] == 8'd0) return {s[31], 63'd0};
    if (s[30:23] == 8'hFF) return {s[31], 11'h7FF, s[22:0], 29'd0};
    return {s[31], 11'(s[30:23]) + 11'd896, s[22:0], 29'd0};
  endfunction

  task automatic scan_rf(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      bus_rd(BASE + 32'(4 * i), v);
      chk(tag, {32'd0, v}, {32'd0, exp_rf[i]});
    end
  endtask

  task automatic run_op(input int k, input bit poke_busy);
    logic [19:0] v;
    logic [4:0]  a, b, d;
    logic        dp;
    logic [63:0] ea, eb, res;
    logic [4:0]  fl;
    logic [31:0] r;
    int n;
    v = VEC[k];
    a = v[4:0]; b = v[9:5]; d = v[14:10]; dp = v[15];
    res = {32'hC0DE_0000 | 32'(k), 32'h5A5A_0000 + 32'(k * 3)};
    fl = 5'(k * 7 + 3);
    // flag bits in the write data must be discarded (R3)
    bus_wr(CTRL, {5'h1F, 7'h7F, v});
    bus_rd(CTRL, r);
    chk("R3 busy+cfg after launch", {32'd0, r}, {32'd0, cur_flags, 6'd0, 1'b1, v});
    n = 0;
    while (!fu_start && n < 50) begin @(negedge clk); n++; end
    chk("R6 start seen", {63'd0, fu_start}, 64'd1);
    ea = dp ? {exp_rf[{a[4:1], 1'b0}], exp_rf[{a[4:1], 1'b1}]} : widen(exp_rf[a]);
    eb = dp ? {exp_rf[{b[4:1], 1'b0}], exp_rf[{b[4:1], 1'b1}]} : widen(exp_rf[b]);
    chk(dp ? "R4 op_a pair" : "R5 op_a widen", fu_op_a, ea);
    chk(dp ? "R4 op_b pair" : "R5 op_b widen", fu_op_b, eb);
    chk("R6 fu_dp", {63'd0, fu_dp}, {63'd0, dp});
    chk("R6 fu_mode", {60'd0, fu_mode}, {60'd0, v[19:16]});
    @(negedge clk);
    chk("R6 start one cycle", {63'd0, fu_start}, 64'd0);
    if (poke_busy) begin
      // R10: register and configuration writes while busy are ignored
      bus_wr(BASE + 32'd80, 32'hDEAD_BEEF);
      bus_wr(CTRL, 32'h000F_FFFF);
    end
    @(negedge clk);
    fu_done = 1; fu_result = res; fu_flags = fl;
    @(negedge clk);
    fu_done = 0; fu_result = 0; fu_flags = 0;
    if (dp) begin
      exp_rf[{d[4:1], 1'b0}] = res[63:32];
      exp_rf[{d[4:1], 1'b1}] = res[31:0];
    end else begin
      exp_rf[d] = res[31:0];
    end
    cur_flags = fl;
    n = 0;
    r = 32'h0010_0000;
    while (r[20] && n < 20) begin bus_rd(CTRL, r); n++; end
    chk("R9 flags and busy clear", {32'd0, r}, {32'd0, fl, 6'd0, 1'b0, v});
    scan_rf(dp ? "R7 dp writeback" : (poke_busy ? "R10 busy writes ignored" : "R8 sp writeback"));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cur_flags = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    chk("R1 start low", {63'd0, fu_start}, 64'd0);
    bus_rd(CTRL, rd);
    chk("R1 cfg word zero", {32'd0, rd}, 64'd0);
    // R2 load and read back the register file
    for (int i = 0; i < 32; i++) begin
      exp_rf[i] = pat(i);
      bus_wr(BASE + 32'(4 * i), exp_rf[i]);
    end
    scan_rf("R2 rf readback");
    bus_rd(BASE + 32'hA0, rd);
    chk("R2 unmapped offset reads 0", {32'd0, rd}, 64'd0);
    // R11 other base and misaligned accesses ignored
    bus_wr(32'hA017_0000, 32'h1234_5678);
    bus_wr(BASE + 32'h0000_0106, 32'h8765_4321);
    bus_wr(BASE + 32'd2, 32'hAAAA_5555);
    bus_rd(BASE, rd);
    chk("R11 foreign base ignored", {32'd0, rd}, {32'd0, exp_rf[0]});
    bus_rd(CTRL, rd);
    chk("R11 cfg untouched", {32'd0, rd}, 64'd0);
    // table of operations
    for (int k = 0; k < NV; k++) run_op(k, k == 2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule